// File: doc/BRIEF.md
# SPI Command Front End with Write-Enable Status

This block is the slave side of a serial command port that sits in front of a small on-chip user memory. The port uses SPI mode 0: the clock idles low, the master changes data while the clock is low, and the slave samples on each rising clock edge. After chip select goes low, the block collects one 8-bit instruction, most significant bit first. It recognises three instructions. One arms a write-enable latch, one disarms it, and one returns a status byte. The latch drives a level output that downstream write logic uses as a gate.

The serial inputs are asynchronous to the block's own clock, so they pass through a synchronizer of configurable depth. Edges of the serial clock are detected in the system clock domain. The master's serial clock must therefore run well below the system clock. A write-enable or write-disable instruction takes effect only when chip select is released after all eight bits have arrived. Any instruction other than a status read puts the port into a hold state, and the port ignores the serial clock until chip select goes high again. The serial output comes with a separate enable that goes to an external tristate buffer.

Top module: `spi_status_front`

## Requirements
- R1: With chip select low, an instruction is formed from the first eight serial-input bits sampled on rising serial-clock edges, first bit received = bit 7. A bit-reversed code is not recognised.
- R2: Instruction 0x06 sets the write-enable latch to 1. The latch appears as status bit 1 and on output `writeEnable`.
- R3: Instruction 0x04 clears the write-enable latch to 0.
- R4: The latch changes only when chip select rises after a complete 8-bit instruction. If chip select rises after fewer than eight bits, the frame is dropped and the latch keeps its value.
- R5: After the eighth bit of 0x06, 0x04 or any code other than 0x05, further serial bits in the same frame are ignored. They neither change the latch nor enable the output. An unrecognised code leaves the latch unchanged.
- R6: `sdOutEn` is 0 while an instruction is being shifted in and whenever chip select is high.
- R7: After instruction 0x05, `sdOutEn` goes to 1 at the falling serial-clock edge that follows the eighth bit. `sdOut` then presents the status byte most significant bit first, advancing on each falling edge, where the status byte is bits 7..2 = 0, bit 1 = latch, bit 0 = 0. Once all eight status bits have been sent, `sdOut` is 0 for the rest of the frame.
- R8: Reset clears the latch to 0 and leaves `sdOutEn` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select from the master |
| sclk | input | 1 | Serial clock from the master (mode 0) |
| sdIn | input | 1 | Serial data from the master |
| sdOut | output | 1 | Serial data to the master |
| sdOutEn | output | 1 | Drive enable for the external tristate on `sdOut` |
| writeEnable | output | 1 | Write-enable latch, status bit 1 |

## Verification
If the bit counter goes wrong, the eighth bit lands in the wrong place. The port then misreads the instruction, and this shows at the next chip-select release as a missing or spurious change on `writeEnable`. A sequencer that does not hold after a one-byte instruction lets trailing bits re-arm or disarm the latch, which shows on the same release. A wrong status word or wrong output-shift timing shows on `sdOut` within the eight falling serial-clock edges after a status read. A wrong enable shows on `sdOutEn` within one serial-clock half period, either while an instruction is being shifted in or after chip select rises.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int CMD_W   = 8;
  localparam int STAT_W  = 8;
  localparam int WEN_POS = 1;

  localparam logic [CMD_W-1:0] OP_SET_WE  = 8'h06;
  localparam logic [CMD_W-1:0] OP_CLR_WE  = 8'h04;
  localparam logic [CMD_W-1:0] OP_READ_ST = 8'h05;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ARM_SET,
    ST_ARM_CLR,
    ST_IGNORE,
    ST_RD_WAIT,
    ST_RD_DRIVE
  } seqState_t;

  typedef struct packed {
    logic clrFrame;
    logic shiftIn;
    logic loadOut;
    logic startDrive;
    logic shiftOut;
    logic setWen;
    logic clrWen;
  } ctrlStrb_t;
endpackage

// File: rtl/spi_stat_dp.sv
module spi_stat_dp
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csNIn,
  input  logic             sclkIn,
  input  logic             sdInRaw,
  input  ctrlStrb_t        strb,
  output logic             csHigh,
  output logic             sckRise,
  output logic             sckFall,
  output logic             lastBit,
  output logic [CMD_W-1:0] rxByte,
  output logic             sdOut,
  output logic             sdOutEn,
  output logic             wenOut
);
  localparam int CNT_W = (CMD_W > 1) ? $clog2(CMD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CMD_W - 1);

  // bit 2 = chip select, bit 1 = serial clock, bit 0 = serial data
  logic [2:0] syncQ [SYNC_STAGES];

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 3'b100;
        else       syncQ[g] <= {csNIn, sclkIn, sdInRaw};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 3'b100;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic csS, sckS, siS, sckPrev;
  assign csS  = syncQ[SYNC_STAGES-1][2];
  assign sckS = syncQ[SYNC_STAGES-1][1];
  assign siS  = syncQ[SYNC_STAGES-1][0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign csHigh  = csS;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;

  logic [CNT_W-1:0] bitCnt;
  logic [CMD_W-1:0] shiftReg;
  logic [STAT_W-1:0] outReg, statusByte;
  logic driveQ, wenQ;

  assign rxByte  = {shiftReg[CMD_W-2:0], siS};
  assign lastBit = (bitCnt == LAST_CNT);

  always_comb begin
    statusByte          = '0;
    statusByte[WEN_POS] = wenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strb.clrFrame) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (strb.shiftIn) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               outReg <= '0;
    else if (strb.loadOut)   outReg <= statusByte;
    else if (strb.shiftOut)  outReg <= {outReg[STAT_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                driveQ <= 1'b0;
    else if (strb.clrFrame)   driveQ <= 1'b0;
    else if (strb.startDrive) driveQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wenQ <= 1'b0;
    else if (strb.setWen) wenQ <= 1'b1;
    else if (strb.clrWen) wenQ <= 1'b0;
  end

  assign sdOut   = driveQ & outReg[STAT_W-1];
  assign sdOutEn = driveQ;
  assign wenOut  = wenQ;

  // R4
  wen_change_at_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wenQ != $past(wenQ)) |-> $past(csS));

  // R6
  no_drive_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !driveQ);

  // R1
  cnt_on_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sckRise && !csS) |=> $stable(bitCnt));
endmodule

// File: rtl/spi_stat_ctrl.sv
module spi_stat_ctrl
  import spi_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csHigh,
  input  logic             sckRise,
  input  logic             sckFall,
  input  logic             lastBit,
  input  logic [CMD_W-1:0] rxByte,
  output ctrlStrb_t        strb
);
  seqState_t state, nxt;

  always_comb begin
    strb = '0;
    nxt  = state;
    if (csHigh) begin
      strb.clrFrame = 1'b1;
      strb.setWen   = (state == ST_ARM_SET);
      strb.clrWen   = (state == ST_ARM_CLR);
      nxt           = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: nxt = ST_CMD;
        ST_CMD: begin
          if (sckRise) begin
            strb.shiftIn = 1'b1;
            if (lastBit) begin
              if (rxByte == OP_SET_WE)       nxt = ST_ARM_SET;
              else if (rxByte == OP_CLR_WE)  nxt = ST_ARM_CLR;
              else if (rxByte == OP_READ_ST) begin
                strb.loadOut = 1'b1;
                nxt          = ST_RD_WAIT;
              end else                       nxt = ST_IGNORE;
            end
          end
        end
        ST_RD_WAIT: begin
          if (sckFall) begin
            strb.startDrive = 1'b1;
            nxt             = ST_RD_DRIVE;
          end
        end
        ST_RD_DRIVE: strb.shiftOut = sckFall;
        default: nxt = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  // R5
  hold_no_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE || state == ST_ARM_SET || state == ST_ARM_CLR)
      |-> !(strb.shiftIn || strb.startDrive || strb.loadOut));

  // R2
  wen_one_op_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setWen, strb.clrWen}));

  // R6
  cmd_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD) |-> !strb.startDrive);
endmodule

// File: rtl/spi_status_front.sv
module spi_status_front
  import spi_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdIn,
  output logic sdOut,
  output logic sdOutEn,
  output logic writeEnable
);
  ctrlStrb_t        strb;
  logic             csHigh, sckRise, sckFall, lastBit;
  logic [CMD_W-1:0] rxByte;

  spi_stat_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .csNIn(csN), .sclkIn(sclk), .sdInRaw(sdIn),
    .strb(strb), .csHigh(csHigh), .sckRise(sckRise), .sckFall(sckFall),
    .lastBit(lastBit), .rxByte(rxByte), .sdOut(sdOut), .sdOutEn(sdOutEn),
    .wenOut(writeEnable)
  );

  spi_stat_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .csHigh(csHigh), .sckRise(sckRise),
    .sckFall(sckFall), .lastBit(lastBit), .rxByte(rxByte), .strb(strb)
  );
endmodule

// File: tb/spi_status_front_tb.sv
module spi_status_front_tb_top;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b0, sdIn = 1'b0;
  logic sdOut, sdOutEn, writeEnable;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  spi_status_front dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdIn(sdIn),
    .sdOut(sdOut), .sdOutEn(sdOutEn), .writeEnable(writeEnable)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HP) @(negedge clk);
  endtask

  task automatic endFrame();
    waitHalf();
    csN = 1'b1;
    waitHalf();
    waitHalf();
  endtask

  // shifts nCmd bits of cmd, then nPost bits of post; samples sdOut/sdOutEn before each post rise
  task automatic frame(input logic [7:0] cmd, input int nCmd, input logic [15:0] post,
                       input int nPost, input bit raiseCs, output logic [15:0] rd,
                       output bit cmdDrove, output bit postAll, output bit postAny);
    rd = '0; cmdDrove = 0; postAll = 1; postAny = 0;
    csN = 1'b0;
    waitHalf();
    for (int i = 0; i < nCmd; i++) begin
      sdIn = cmd[7-i];
      waitHalf();
      if (sdOutEn) cmdDrove = 1;
      sclk = 1'b1;
      waitHalf();
      sclk = 1'b0;
    end
    for (int i = 0; i < nPost; i++) begin
      sdIn = post[15-i];
      waitHalf();
      rd[15-i] = sdOut;
      if (sdOutEn) postAny = 1; else postAll = 0;
      sclk = 1'b1;
      waitHalf();
      sclk = 1'b0;
    end
    if (raiseCs) endFrame();
  endtask

  task automatic readStatus(input logic [7:0] exp, input string tag);
    logic [15:0] rd; bit d, a, n;
    frame(8'h05, 8, 16'h0000, 8, 1, rd, d, a, n);
    check({"R7 status byte ", tag}, rd[15:8], exp);
    check("R7 output enabled during status", a, 1);
    check("R6 no drive during instruction", d, 0);
    check("R6 no drive after cs high", sdOutEn, 0);
  endtask

  task automatic t_reset();
    check("R8 latch after reset", writeEnable, 0);
    check("R8 enable after reset", sdOutEn, 0);
    readStatus(8'h00, "after reset");
  endtask

  task automatic t_setWen();
    logic [15:0] rd; bit d, a, n;
    frame(8'h06, 8, 16'h0, 0, 0, rd, d, a, n);
    waitHalf();
    check("R4 latch unchanged before cs rise", writeEnable, 0);
    endFrame();
    check("R2 latch set by 0x06", writeEnable, 1);
    readStatus(8'h02, "with latch set");
  endtask

  task automatic t_abort();
    logic [15:0] rd; bit d, a, n;
    frame(8'h04, 5, 16'h0, 0, 1, rd, d, a, n);
    check("R4 short frame keeps latch", writeEnable, 1);
    frame(8'h06, 7, 16'h0, 0, 1, rd, d, a, n);
    check("R4 short frame keeps latch (set)", writeEnable, 1);
  endtask

  task automatic t_clrWen();
    logic [15:0] rd; bit d, a, n;
    frame(8'h04, 8, 16'h0, 0, 1, rd, d, a, n);
    check("R3 latch cleared by 0x04", writeEnable, 0);
    readStatus(8'h00, "after clear");
  endtask

  task automatic t_bitOrder();
    logic [15:0] rd; bit d, a, n;
    frame(8'h60, 8, 16'h0, 0, 1, rd, d, a, n);
    check("R1 reversed code not recognised", writeEnable, 0);
  endtask

  task automatic t_tail();
    logic [15:0] rd; bit d, a, n;
    frame(8'h06, 8, 16'h0400, 8, 1, rd, d, a, n);
    check("R5 trailing 0x04 ignored after 0x06", writeEnable, 1);
    check("R5 no drive in hold", n, 0);
    frame(8'h04, 8, 16'h0600, 8, 1, rd, d, a, n);
    check("R5 trailing 0x06 ignored after 0x04", writeEnable, 0);
  endtask

  task automatic t_unknown();
    logic [15:0] rd; bit d, a, n;
    frame(8'hA5, 8, 16'h0506, 16, 1, rd, d, a, n);
    check("R5 unknown code leaves latch", writeEnable, 0);
    check("R5 unknown code no drive", n, 0);
    frame(8'h06, 8, 16'h0, 0, 1, rd, d, a, n);
    frame(8'h07, 8, 16'h0400, 8, 1, rd, d, a, n);
    check("R5 unknown code keeps latch set", writeEnable, 1);
  endtask

  task automatic t_longRead();
    logic [15:0] rd; bit d, a, n;
    frame(8'h05, 8, 16'h0, 16, 1, rd, d, a, n);
    check("R7 status then zeros", rd, 16'h0200);
    check("R7 enable held whole frame", a, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bitOrder();
    t_setWen();
    t_abort();
    t_clrWen();
    t_tail();
    t_unknown();
    t_longRead();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule